// File: doc/BRIEF.md
# Clock Tree Controller

This block builds the clock tree of a small microcontroller. It takes four free-running source clocks and picks one of them as the always-on slow clock: a ring oscillator, a trimmed RC oscillator, a crystal driver or an external clock input. That clock, or a PLL output, becomes the fast clock. A bus clock and an auxiliary timer clock are derived from the fast clock through two independent power-of-two dividers. When deep sleep is requested, seven peripheral clocks are gated off. The always-on clock keeps running so that the real-time clock and the watchdog stay alive.

Configuration arrives as a single write word that is captured on the bus clock. Both source selections are made through a break-before-make handover. The old source is released on its own falling edge, and the new source is taken only after two of its own rising edges followed by a falling edge. No output pulse can therefore be shorter than half a period of either clock. A status output reports when the requested sources are actually driving the tree. The block also drives the ring oscillator's 2-bit frequency setting.

Top module: `clk_tree_ctrl`

## Requirements
- R1: `cfg_wdata[1:0]` selects the always-on clock `frclk`: 0 ring oscillator (`src_clk[0]`), 1 RC oscillator (`src_clk[1]`), 2 crystal (`src_clk[2]`), 3 external input (`src_clk[3]`); `frclk` runs at the selected source's frequency.
- R2: `cfg_wdata[2]` picks the fast clock `fclk`: 0 passes `frclk` through, 1 selects `pll_clk`.
- R3: `hclk` is `fclk` divided by 2^`cfg_wdata[4:3]` (1, 2, 4 or 8) at 50% duty.
- R4: `aclk` is `fclk` divided by 2^`cfg_wdata[7:5]` (1 up to 128) at 50% duty, independent of the `hclk` ratio.
- R5: After reset the ring oscillator is selected, `ring_trim` is 0 (slowest setting), the PLL is bypassed and both dividers are at 1.
- R6: `ring_trim` follows `cfg_wdata[9:8]` after a write; a higher code gives a faster ring oscillator.
- R7: While `sleep_req` is high, `gclk` stays low (bit 0 timer on `aclk`, bit 1 ADC on `fclk`, bits 2..6 SPI, I2C, UART, memory and CPU on `hclk`), while `frclk` and `hclk` keep running; the gated clocks resume after `sleep_req` falls.
- R8: A source change gives no `frclk` or `fclk` pulse shorter than half a period of the old or new clock, at most one source of each selector drives it at any time, and `sw_done` is high exactly when both requested sources drive the tree.
- R9: A new divide ratio takes effect only when the divider finishes its current period; the period in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Source clocks: ring, RC, crystal, external |
| pll_clk | input | 1 | PLL output clock |
| cfg_wr | input | 1 | Configuration write strobe, sampled on `hclk` |
| cfg_wdata | input | 10 | Configuration word (fields in R1 to R6) |
| sleep_req | input | 1 | Deep-sleep request |
| ring_trim | output | 2 | Ring oscillator frequency setting |
| frclk | output | 1 | Always-on free-running clock |
| fclk | output | 1 | Fast clock |
| hclk | output | 1 | Bus clock |
| aclk | output | 1 | Auxiliary timer clock |
| gclk | output | 7 | Sleep-gated peripheral clocks |
| sw_done | output | 1 | Requested sources are in effect |

## Verification
Every source code is selected in turn, each with its own distinct period. The edge count over a fixed window therefore tells which source really drives `frclk`, and a crossed or stuck selector shows up as a wrong count. The four ring settings, the PLL and bypass paths, and several pairs of divider ratios are measured the same way. Because the two dividers are set to different ratios, swapped divider fields or a shared divider show up in the counts. During each switch the bench records the shortest pulse it sees, which exposes a glitch. A ratio change is written just after the slow auxiliary clock rises, so an early update breaks its long high phase. Sleep is entered and left while the gated and ungated clocks are watched together.

// File: rtl/clk_tree_ctrl.sv
module clk_tree_ctrl (
  input  logic       rst_n,
  input  logic [3:0] src_clk,
  input  logic       pll_clk,
  input  logic       cfg_wr,
  input  logic [9:0] cfg_wdata,
  input  logic       sleep_req,
  output logic [1:0] ring_trim,
  output logic       frclk,
  output logic       fclk,
  output logic       hclk,
  output logic       aclk,
  output logic [6:0] gclk,
  output logic       sw_done
);

  logic [1:0] src_q, hdiv_c, trim_q;
  logic       pll_q;
  logic [2:0] adiv_c;

  always_ff @(posedge hclk or negedge rst_n)
    if (!rst_n) begin
      src_q <= 2'd0; pll_q <= 1'b0; hdiv_c <= 2'd0; adiv_c <= 3'd0; trim_q <= 2'd0;
    end else if (cfg_wr) begin
      src_q  <= cfg_wdata[1:0];
      pll_q  <= cfg_wdata[2];
      hdiv_c <= cfg_wdata[4:3];
      adiv_c <= cfg_wdata[7:5];
      trim_q <= cfg_wdata[9:8];
    end

  assign ring_trim = trim_q;

  // break-before-make source select for the always-on clock
  logic [3:0] fr_en, fr_req;
  for (genvar i = 0; i < 4; i++) begin : g_fr
    logic s1, s2, en_q;
    assign fr_req[i] = (src_q == 2'(i)) && !(|(fr_en & ~(4'b1 << i)));
    always_ff @(posedge src_clk[i] or negedge rst_n)
      if (!rst_n) {s2, s1} <= 2'b00;
      else        {s2, s1} <= {s1, fr_req[i]};
    always_ff @(negedge src_clk[i] or negedge rst_n)
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= s2;
    assign fr_en[i] = en_q;
  end
  assign frclk = |(src_clk & fr_en);

  // same handover between bypass and PLL
  logic [1:0] fsrc, fc_en, fc_req;
  assign fsrc = {pll_clk, frclk};
  for (genvar j = 0; j < 2; j++) begin : g_fc
    logic s1, s2, en_q;
    assign fc_req[j] = (pll_q == 1'(j)) && !fc_en[1-j];
    always_ff @(posedge fsrc[j] or negedge rst_n)
      if (!rst_n) {s2, s1} <= 2'b00;
      else        {s2, s1} <= {s1, fc_req[j]};
    always_ff @(negedge fsrc[j] or negedge rst_n)
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= s2;
    assign fc_en[j] = en_q;
  end
  assign fclk    = |(fsrc & fc_en);
  assign sw_done = fr_en[src_q] & fc_en[pll_q];

  // dividers: ratio reloads when the running period ends
  logic [2:0] hcnt;
  logic [1:0] h_q, h_n;
  logic [6:0] acnt;
  logic [2:0] a_q, a_n;
  logic       h_term, a_term;

  assign h_term = hcnt == ((3'd1 << h_q) - 3'd1);
  assign a_term = acnt == ((7'd1 << a_q) - 7'd1);

  always_ff @(posedge fclk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= 3'd0; h_q <= 2'd0; acnt <= 7'd0; a_q <= 3'd0;
    end else begin
      if (h_term) begin hcnt <= 3'd0; h_q <= hdiv_c; end
      else hcnt <= hcnt + 3'd1;
      if (a_term) begin acnt <= 7'd0; a_q <= adiv_c; end
      else acnt <= acnt + 7'd1;
    end

  // output selects move on the low phase of fclk
  always_ff @(negedge fclk or negedge rst_n)
    if (!rst_n) begin h_n <= 2'd0; a_n <= 3'd0; end
    else        begin h_n <= h_q;  a_n <= a_q;  end

  assign hclk = (h_n == 2'd0) ? fclk : hcnt[h_n - 2'd1];
  assign aclk = (a_n == 3'd0) ? fclk : acnt[a_n - 3'd1];

  // deep-sleep gating with low-phase latches
  logic slp_m, slp_s;
  always_ff @(posedge hclk or negedge rst_n)
    if (!rst_n) {slp_s, slp_m} <= 2'b00;
    else        {slp_s, slp_m} <= {slp_m, sleep_req};

  logic [6:0] gsrc;
  assign gsrc = {hclk, hclk, hclk, hclk, hclk, fclk, aclk};
  for (genvar k = 0; k < 7; k++) begin : g_gate
    logic on_l;
    always_latch
      if (!gsrc[k]) on_l = !slp_s;
    assign gclk[k] = gsrc[k] & on_l;
  end

  a_r8_fr_onehot: assert property (@(posedge pll_clk) disable iff (!rst_n)
    $onehot0(fr_en));
  a_r8_fc_onehot: assert property (@(posedge pll_clk) disable iff (!rst_n)
    $onehot0(fc_en));
  a_r9_h_hold: assert property (@(posedge fclk) disable iff (!rst_n)
    !$past(h_term) |-> $stable(h_q));
  a_r9_a_hold: assert property (@(posedge fclk) disable iff (!rst_n)
    !$past(a_term) |-> $stable(a_q));
  a_r5_reset_default: assert property (@(posedge pll_clk)
    $rose(rst_n) |-> (trim_q == 2'd0 && src_q == 2'd0 && !pll_q && hdiv_c == 2'd0 && adiv_c == 3'd0));

endmodule

// File: tb/sim_clk_tree_ctrl.sv
`timescale 1ns/1ps
module sim_clk_tree_ctrl;
  logic       rst_n = 1'b0;
  logic [3:0] src_clk = 4'b0;
  logic       pll_clk = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [9:0] cfg_wdata = 10'd0;
  logic       sleep_req = 1'b0;
  logic [1:0] ring_trim;
  logic       frclk, fclk, hclk, aclk, sw_done;
  logic [6:0] gclk;

  int checks = 0, errors = 0;

  clk_tree_ctrl u0 (.rst_n(rst_n), .src_clk(src_clk), .pll_clk(pll_clk), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .sleep_req(sleep_req), .ring_trim(ring_trim), .frclk(frclk),
    .fclk(fclk), .hclk(hclk), .aclk(aclk), .gclk(gclk), .sw_done(sw_done));

  // 125 MHz PLL clock; ring period 40/32/24/16 ns by trim code
  always #4 pll_clk = ~pll_clk;
  always begin
    case (ring_trim)
      2'd0: #20; 2'd1: #16; 2'd2: #12; default: #8;
    endcase
    src_clk[0] = ~src_clk[0];
  end
  always #25 src_clk[1] = ~src_clk[1];
  always #10 src_clk[2] = ~src_clk[2];
  always #30 src_clk[3] = ~src_clk[3];

  logic on = 1'b0;
  int nfr, nf, nh, na, ng0, ng6;
  bit g_hi;
  realtime tfr = 0, tf = 0, ta = 0, mfr, mf, ma;

  always @(posedge frclk)  if (on) nfr++;
  always @(posedge fclk)   if (on) nf++;
  always @(posedge hclk)   if (on) nh++;
  always @(posedge aclk)   if (on) na++;
  always @(posedge gclk[0]) if (on) ng0++;
  always @(posedge gclk[6]) if (on) ng6++;
  always @(gclk) if (on && gclk != 7'd0) g_hi = 1'b1;
  always @(frclk) begin if (on && $realtime - tfr < mfr) mfr = $realtime - tfr; tfr = $realtime; end
  always @(fclk)  begin if (on && $realtime - tf  < mf)  mf  = $realtime - tf;  tf  = $realtime; end
  always @(aclk)  begin if (on && $realtime - ta  < ma)  ma  = $realtime - ta;  ta  = $realtime; end

  task automatic clr();
    nfr = 0; nf = 0; nh = 0; na = 0; ng0 = 0; ng6 = 0; g_hi = 1'b0;
    mfr = 1e9; mf = 1e9; ma = 1e9;
  endtask

  task automatic meas(input int w);
    clr(); on = 1'b1; #w; on = 1'b0;
  endtask

  task automatic chk(input string r, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_ge(input string r, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s: got %0d expected at least %0d", r, act, lim);
    end
  endtask

  function automatic logic [9:0] cw(input int s, input int p, input int h, input int a, input int t);
    return {2'(t), 3'(a), 2'(h), 1'(p), 2'(s)};
  endfunction

  task automatic wr(input logic [9:0] d);
    @(negedge hclk); cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge hclk); #1 cfg_wr = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (sw_done) begin ok = 1'b1; break; end
      #2;
    end
  endtask

  task automatic t_reset();
    chk("R5 trim", int'(ring_trim), 0, 0);
    chk("R8 done", int'(sw_done), 1, 0);
    meas(4000);
    chk("R5 frclk ring slowest", nfr, 100, 2);
    chk("R2 bypass", nf, 100, 2);
    chk("R3 hclk div1", nh, 100, 2);
    chk("R4 aclk div1", na, 100, 2);
  endtask

  task automatic t_sources();
    int per[4] = '{40, 50, 20, 60};
    bit ok;
    for (int s = 1; s < 4; s++) begin
      clr(); on = 1'b1;
      wr(cw(s, 0, 0, 0, 0));
      #1 chk("R8 done low", int'(sw_done), 0, 0);
      wait_done(ok);
      #200 on = 1'b0;
      chk("R8 done", int'(ok), 1, 0);
      chk_ge("R8 frclk glitch", int'(mfr * 10), 79);
      meas(4000);
      chk("R1 source freq", nfr, (4000 + per[s] / 2) / per[s], 2);
    end
  endtask

  task automatic t_trim();
    int per[4] = '{40, 32, 24, 16};
    bit ok;
    for (int t = 3; t >= 1; t--) begin
      wr(cw(0, 0, 0, 0, t));
      wait_done(ok);
      #200;
      chk("R6 trim port", int'(ring_trim), t, 0);
      meas(4000);
      chk("R6 ring freq", nfr, 4000 / per[t], 2);
    end
  endtask

  task automatic t_pll();
    bit ok;
    clr(); on = 1'b1;
    wr(cw(0, 1, 0, 0, 1));
    wait_done(ok);
    #200 on = 1'b0;
    chk("R8 pll done", int'(ok), 1, 0);
    chk_ge("R8 fclk glitch", int'(mf * 10), 39);
    meas(4000);
    chk("R2 pll fclk", nf, 500, 2);
    chk("R2 frclk kept", nfr, 125, 2);
  endtask

  task automatic t_div();
    wr(cw(0, 1, 2, 5, 1)); #3000;
    meas(16384);
    chk("R3 hclk div4", nh, 512, 2);
    chk("R4 aclk div32", na, 64, 2);
    chk_ge("R4 aclk duty", int'(ma * 10), 1279);
    wr(cw(0, 1, 3, 7, 1)); #3000;
    meas(16384);
    chk("R3 hclk div8", nh, 256, 2);
    chk("R4 aclk div128", na, 16, 2);
    wr(cw(0, 1, 1, 0, 1)); #3000;
    meas(16384);
    chk("R3 hclk div2", nh, 1024, 2);
    chk("R4 aclk div1", na, 2048, 2);
  endtask

  task automatic t_divchg();
    realtime t0;
    bit low_seen = 1'b0;
    wr(cw(0, 1, 1, 7, 1)); #3000;
    clr(); on = 1'b1;
    @(posedge aclk); t0 = $realtime;
    wr(cw(0, 1, 1, 1, 1));
    while ($realtime < t0 + 500) begin
      #2 if (!aclk) low_seen = 1'b1;
    end
    chk("R9 old period kept", int'(low_seen), 0, 0);
    #(t0 + 1200 - $realtime);
    on = 1'b0;
    chk_ge("R9 aclk glitch", int'(ma * 10), 79);
    meas(2000);
    chk("R9 new ratio", na, 125, 2);
  endtask

  task automatic t_sleep();
    wr(cw(0, 1, 1, 2, 1)); #2000;
    meas(4000);
    chk("R7 awake cpu", ng6, 250, 2);
    chk("R7 awake timer", ng0, 125, 2);
    sleep_req = 1'b1; #500;
    meas(4000);
    chk("R7 gated", int'(g_hi), 0, 0);
    chk("R7 frclk runs", nfr, 125, 2);
    chk("R7 hclk runs", nh, 250, 2);
    sleep_req = 1'b0; #500;
    meas(4000);
    chk("R7 resume cpu", ng6, 250, 2);
    chk("R7 resume timer", ng0, 125, 2);
  endtask

  initial begin
    #100 rst_n = 1'b1;
    #1000;
    t_reset();
    t_sources();
    t_trim();
    t_pll();
    t_div();
    t_divchg();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule